// File: doc/BRIEF.md
# SPI Slave with Transmit Preload

This block is an SPI slave that lives entirely in the system clock domain. SCK, MOSI and the active-low select are brought in through synchronizer chains. Edges of the synchronized SCK then drive an 8-bit transfer in mode 0, MSB first. MOSI is captured on rising SCK. MISO moves on falling SCK. A single-entry transmit holding register takes characters from the local side. Each completed incoming character is placed in a receive register and marked with a one-cycle valid pulse.

At every character boundary, the transmit shift register reloads from the holding register if a character is waiting. If nothing is waiting, it keeps what it just sent. A new transaction therefore normally starts by repeating the previous transaction's last character, or 8'h00 after reset. With `preload_en` set, the block moves one waiting character into the shift register while it is deselected. The first character of the next transaction is then real data.

A two-state machine controls the block. `ST_IDLE` means deselected. It goes to `ST_SHIFT` when the synchronized select falls (transition SEL_FALL). `ST_SHIFT` returns to `ST_IDLE` when the synchronized select rises (transition SEL_RISE). Preloading happens only in `ST_IDLE`. Shifting and boundary loads happen only in `ST_SHIFT`.

Top module: `spi_preload_slave`

## Requirements
- R1: After reset, `tx_empty` is 1, `rx_valid` is 0, `miso_oe` is 0, and the transmit shift register holds 8'h00. The first character sent after reset with no preload is therefore 8'h00.
- R2: After the 8th rising SCK edge of a character, `rx_data` holds the 8 MOSI bits, with the first bit as bit 7. `rx_valid` is high for exactly one clock cycle.
- R3: While selected, `miso_out` carries the transmit shift register MSB first. It changes only after falling SCK edges, so each bit is stable at the next rising edge.
- R4: With preload disabled, the first character of a transaction is the shift register content: 8'h00 after reset, otherwise the last character of the previous transaction. This holds even if a character is waiting in the holding register.
- R5: With `preload_en` = 1, a waiting character moves into the shift register while deselected. `tx_empty` returns to 1, and that character is the first one sent.
- R6: Only one character is moved per deselected period. A second write before select falls stays waiting (`tx_empty` = 0) and is sent as the second character.
- R7: At the falling SCK edge after each 8th bit, a waiting character loads and `tx_empty` becomes 1. If no character is waiting, the same character is sent again.
- R8: A write while a character is already waiting overwrites it. Only the newest value is sent.
- R9: While the synchronized select is high, `miso_oe` is 0 and the bit count is cleared. A partial character is dropped without a receive pulse, and the next transaction starts a fresh character.
- R10: With `preload_en` = 0, nothing moves into the shift register while deselected. `tx_empty` stays 0 while a character waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_in | input | 1 | Serial clock from the master (idle low) |
| mosi_in | input | 1 | Serial data from the master |
| ss_n_in | input | 1 | Active-low slave select |
| preload_en | input | 1 | Allows one preload per deselected period |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Character to transmit |
| tx_empty | output | 1 | High when no transmit character is waiting |
| rx_data | output | 8 | Last complete received character |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` updates |
| miso_out | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for MISO (tri-state control) |

## Verification
Every serial input passes two synchronizer flops and one edge-detect flop, so an SCK edge acts on the third clock after it. `rx_valid` appears about three clocks after the 8th rising edge. A MISO change appears about three clocks after a falling edge. The bench holds each SCK half-period for eight clocks and waits eight clocks between a select change and the first edge. It samples MISO just before raising SCK and reads `tx_empty` a full half-period after the boundary falling edge, so every result has settled. Received characters go into a scoreboard queue and are popped whenever a pulse is seen, whatever cycle it lands in.

// File: rtl/spi_pre_pkg.sv
package spi_pre_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } slv_state_t;
endpackage

// File: rtl/spi_pre_sync.sv
module spi_pre_sync #(
    parameter int          W      = 3,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RSTV  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    chain[s] <= RSTV;
                else if (s == 0)
                    chain[s] <= d;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_pre_edge.sv
module spi_pre_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
    assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/spi_pre_txbuf.sv
module spi_pre_txbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (wr) begin
                full <= 1'b1;
                data <= wdata;
            end else if (take) begin
                full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_preload_slave.sv
module spi_preload_slave
    import spi_pre_pkg::*;
#(
    parameter int          DW          = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [DW-1:0] SHREG_RST = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_in,
    input  logic          mosi_in,
    input  logic          ss_n_in,
    input  logic          preload_en,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_data,
    output logic          tx_empty,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          miso_out,
    output logic          miso_oe
);
    localparam int CW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    logic          sck_s, mosi_s, ss_s;
    logic          sck_rise, sck_fall;
    logic          buf_full;
    logic [DW-1:0] buf_data;
    logic          take_pre, take_bnd, take;

    slv_state_t    st, st_nx;
    logic [DW-1:0] shreg;
    logic [DW-1:0] rxsh;
    logic [CW-1:0] cnt;
    logic          byte_done;
    logic          preloaded;

    spi_pre_sync #(.W(3), .STAGES(SYNC_STAGES), .RSTV(3'b001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_in, mosi_in, ss_n_in}),
        .q     ({sck_s, mosi_s, ss_s})
    );

    spi_pre_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sck_s),
        .rise  (sck_rise),
        .fall  (sck_fall)
    );

    spi_pre_txbuf #(.DW(DW)) u_txbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (tx_wr),
        .wdata (tx_data),
        .take  (take),
        .full  (buf_full),
        .data  (buf_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next state: SEL_FALL and SEL_RISE
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (!ss_s) st_nx = ST_SHIFT;
            ST_SHIFT: if (ss_s)  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    assign take_pre = (st == ST_IDLE) && ss_s && preload_en && buf_full && !preloaded;
    assign take_bnd = (st == ST_SHIFT) && sck_fall && byte_done && buf_full;
    assign take     = take_pre | take_bnd;

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= SHREG_RST;
            rxsh      <= '0;
            cnt       <= '0;
            byte_done <= 1'b0;
            preloaded <= 1'b0;
            rx_data   <= '0;
            rx_valid  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    cnt       <= '0;
                    byte_done <= 1'b0;
                    if (take_pre) begin
                        shreg     <= buf_data;
                        preloaded <= 1'b1;
                    end
                    if (!ss_s) preloaded <= 1'b0;
                end
                ST_SHIFT: begin
                    if (sck_rise) begin
                        rxsh <= {rxsh[DW-2:0], mosi_s};
                        if (cnt == LAST_BIT) begin
                            cnt       <= '0;
                            byte_done <= 1'b1;
                            rx_data   <= {rxsh[DW-2:0], mosi_s};
                            rx_valid  <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    if (sck_fall) begin
                        byte_done <= 1'b0;
                        if (take_bnd)
                            shreg <= buf_data;
                        else
                            shreg <= {shreg[DW-2:0], shreg[DW-1]};
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        tx_empty = !buf_full;
        miso_out = shreg[DW-1];
        unique case (st)
            ST_IDLE:  miso_oe = 1'b0;
            ST_SHIFT: miso_oe = 1'b1;
            default:  miso_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/spi_pre_chk.sv
module spi_pre_chk
    import spi_pre_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  slv_state_t    st,
    input  logic          ss_s,
    input  logic [CW-1:0] cnt,
    input  logic [DW-1:0] shreg,
    input  logic          preloaded,
    input  logic          preload_en,
    input  logic          tx_wr,
    input  logic          tx_empty,
    input  logic          rx_valid,
    input  logic          miso_oe
);
    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R2

    AST_CNT_CLEAR_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |=> (cnt == '0)); // R9

    AST_OE_OFF_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_s && st == ST_IDLE) |=> !miso_oe); // R9

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !tx_empty); // R8

    AST_SINGLE_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && preloaded) |=> $stable(shreg)); // R6

    AST_NO_PRELOAD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !preload_en) |=> $stable(shreg)); // R10

    AST_PRELOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && ss_s && preload_en && !preloaded && !tx_empty && !tx_wr)
        |=> tx_empty); // R5
endmodule

bind spi_preload_slave spi_pre_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st),
    .ss_s       (ss_s),
    .cnt        (cnt),
    .shreg      (shreg),
    .preloaded  (preloaded),
    .preload_en (preload_en),
    .tx_wr      (tx_wr),
    .tx_empty   (tx_empty),
    .rx_valid   (rx_valid),
    .miso_oe    (miso_oe)
);

// File: tb/tb_spi_preload_slave.sv
module tb_spi_preload_slave;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       ss_n = 1'b1;
    logic       preload_en = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_empty;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       miso_out;
    logic       miso_oe;

    int checks = 0;
    int errors = 0;
    logic [7:0] rx_q[$];
    logic       prev_valid = 1'b0;

    always #4 clk = ~clk;

    spi_preload_slave dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_in     (sck),
        .mosi_in    (mosi),
        .ss_n_in    (ss_n),
        .preload_en (preload_en),
        .tx_wr      (tx_wr),
        .tx_data    (tx_data),
        .tx_empty   (tx_empty),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .miso_out   (miso_out),
        .miso_oe    (miso_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        tx_wr = 1'b1;
        tx_data = d;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic sel();
        @(negedge clk);
        ss_n = 1'b0;
        clks(HALF);
    endtask

    task automatic desel();
        clks(HALF);
        ss_n = 1'b1;
        clks(HALF);
    endtask

    // driver: pushes expected receive item, shifts bits, checks MISO
    task automatic xfer(input logic [7:0] mo, input logic [7:0] exp_miso, input string req);
        logic [7:0] got;
        rx_q.push_back(mo);
        for (int i = 7; i >= 0; i--) begin
            mosi = mo[i];
            clks(HALF);
            got[i] = miso_out;
            sck = 1'b1;
            clks(HALF);
            sck = 1'b0;
        end
        clks(HALF);
        check(req, got, exp_miso);
    endtask

    task automatic partial(input int nbits);
        for (int i = 0; i < nbits; i++) begin
            mosi = 1'b1;
            clks(HALF);
            sck = 1'b1;
            clks(HALF);
            sck = 1'b0;
        end
    endtask

    // monitor: pops scoreboard on every receive pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid && prev_valid) begin
                checks++;
                errors++;
                $display("FAIL R2: actual rx_valid high 2 cycles expected 1");
            end
            if (rx_valid) begin
                if (rx_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R9: actual unexpected rx %h expected none", rx_data);
                end else begin
                    check("R2 rx_data", rx_data, rx_q.pop_front());
                end
            end
            prev_valid = rx_valid;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clks(4);
        rst_n = 1'b1;
        clks(4);
        // R1 reset state
        check("R1 tx_empty", {7'd0, tx_empty}, 8'd1);
        check("R1 rx_valid", {7'd0, rx_valid}, 8'd0);
        check("R1 miso_oe", {7'd0, miso_oe}, 8'd0);

        // R10 no preload while disabled
        wr(8'hA5);
        clks(10);
        check("R10 tx_empty stays low", {7'd0, tx_empty}, 8'd0);
        sel();
        check("R9 miso_oe selected", {7'd0, miso_oe}, 8'd1);
        xfer(8'h3C, 8'h00, "R4 R1 reset char first");
        check("R7 boundary load empties", {7'd0, tx_empty}, 8'd1);
        xfer(8'h81, 8'hA5, "R7 loaded char R3");
        xfer(8'h0F, 8'hA5, "R7 retransmit when empty");
        desel();
        check("R9 miso_oe deselected", {7'd0, miso_oe}, 8'd0);

        // R4 last char of previous transaction first
        wr(8'h5A);
        sel();
        xfer(8'hF0, 8'hA5, "R4 previous last char");
        xfer(8'h55, 8'h5A, "R7 pending after first");
        desel();

        // R5 / R6 preload
        preload_en = 1'b1;
        wr(8'hC3);
        clks(10);
        check("R5 preload empties", {7'd0, tx_empty}, 8'd1);
        wr(8'h7E);
        clks(10);
        check("R6 second stays pending", {7'd0, tx_empty}, 8'd0);
        sel();
        xfer(8'hAA, 8'hC3, "R5 preloaded first");
        xfer(8'h01, 8'h7E, "R6 second char");
        desel();

        // R8 overwrite
        preload_en = 1'b0;
        wr(8'h11);
        wr(8'h22);
        sel();
        xfer(8'h80, 8'h7E, "R4 last char again");
        xfer(8'hFE, 8'h22, "R8 newest value sent");
        desel();

        // R9 partial character discarded, count cleared
        sel();
        partial(3);
        desel();
        clks(10);
        check("R9 no pending rx", rx_q.size() == 0 ? 8'd0 : 8'd1, 8'd0);
        sel();
        rx_q.push_back(8'h96);
        for (int i = 7; i >= 0; i--) begin
            mosi = (8'h96 >> i) & 1'b1;
            clks(HALF);
            sck = 1'b1;
            clks(HALF);
            sck = 1'b0;
        end
        clks(HALF);
        desel();
        check("R9 fresh char received", rx_q.size() == 0 ? 8'd0 : 8'd1, 8'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule